// File: doc/BRIEF.md
# Hierarchical Pulsed Wordline Decoder

This block is a cycle-level model of a three-level RAM row decoder arranged as a divided wordline. A single-cycle access strobe captures a block number and a row number. The row number is split into a low half and a high half. Each half drives its own predecoder, which raises exactly one of its one-hot lines. Each global wordline is the two-input AND of one line from each predecoder. Each local wordline is the two-input AND of a global wordline and one block's select pulse.

The wordline is a timed pulse, not a level. Its width comes only from the block-select pulse, which lasts a parameter number of clock cycles no matter how long the strobe is held. The global wordline rises one cycle before the block select and falls one cycle after it, so it always covers the select pulse. A busy output is high while a pulse is in progress, and any strobe seen during that time is dropped.

Top module: `hwl_decoder`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), every predecode line, global wordline, block select and local wordline is 0, and busy is 0. This also holds when reset arrives during a pulse.
- R2: While a pulse is in progress, pre_lo is one-hot at bit row[ROW_W/2-1:0] and pre_hi is one-hot at bit row[ROW_W-1:ROW_W/2]. Both are 0 when idle.
- R3: While a pulse is in progress, exactly one global wordline is high, at index row, which is pre_hi index × 2^(ROW_W/2) + pre_lo index.
- R4: Local wordline bit blk × 2^ROW_W + row is high exactly when global wordline row and block select blk are both high.
- R5: At most one local wordline and at most one block select are high at any time, and only the captured block's select line ever pulses.
- R6: If a strobe is accepted at clock edge n, the global wordline is high after edges n through n+SEL_CYC+1, i.e. for SEL_CYC+2 cycles. Block select is high after edges n+1 through n+SEL_CYC, i.e. for SEL_CYC cycles.
- R7: Block select rises only while the global wordline is already high, and the global wordline is still high in the cycle after block select falls.
- R8: busy is high from the edge that accepts a strobe until the edge at which the global wordline falls. A strobe sampled while busy is high is ignored: it changes neither the captured address nor the pulse. Holding the strobe high for several cycles therefore does not widen the pulse.
- R9: A strobe sampled in the first cycle after busy falls is accepted, so pulses may follow each other with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Access request, sampled on the rising edge |
| blk_addr | input | BLK_W | Block number captured on an accepted strobe |
| row_addr | input | ROW_W | Row number captured on an accepted strobe |
| busy | output | 1 | Pulse in progress; strobes are ignored |
| pre_lo | output | 2^(ROW_W/2) | One-hot predecode of the low row half |
| pre_hi | output | 2^(ROW_W/2) | One-hot predecode of the high row half |
| gwl | output | 2^ROW_W | Global wordlines |
| bsel | output | N_BLK | Block select pulses |
| lwl | output | N_BLK·2^ROW_W | Local wordlines, block-major |

## Verification
Two things can happen in the same cycle: a new strobe, and the final cycle of the pulse already in progress. The same applies to a strobe arriving at any point inside a pulse. The bench launches a pulse, then drives a strobe with a different address either in the first busy cycle or in the last one. The scoreboard holds no entry for that strobe, so any extra pulse, or a pulse moved to the wrong row or block, is reported. A strobe sent right after busy falls must produce a pulse one idle cycle later with the new address, and strobes held for many cycles must still give one pulse of normal width.

// File: rtl/hwl_decoder.sv
module hwl_decoder #(
  parameter int ROW_W   = 4,
  parameter int N_BLK   = 4,
  parameter int SEL_CYC = 3,
  parameter int BLK_W   = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strobe,
  input  logic [BLK_W-1:0]          blk_addr,
  input  logic [ROW_W-1:0]          row_addr,
  output logic                      busy,
  output logic [(1<<(ROW_W/2))-1:0] pre_lo,
  output logic [(1<<(ROW_W/2))-1:0] pre_hi,
  output logic [(1<<ROW_W)-1:0]     gwl,
  output logic [N_BLK-1:0]          bsel,
  output logic [N_BLK*(1<<ROW_W)-1:0] lwl
);
  localparam int HALF  = ROW_W / 2;
  localparam int NPRE  = 1 << HALF;
  localparam int NROW  = 1 << ROW_W;
  localparam int CNT_W = $clog2(SEL_CYC + 2) + 1;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(SEL_CYC + 1);
  localparam logic [CNT_W-1:0] SEL_C  = CNT_W'(SEL_CYC);

  logic             act;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] blk_r;
  logic [ROW_W-1:0] row_r;
  logic             sel_win;

  wire accept = strobe & ~act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      cnt   <= '0;
      blk_r <= '0;
      row_r <= '0;
    end else if (accept) begin
      act   <= 1'b1;
      cnt   <= '0;
      blk_r <= blk_addr;
      row_r <= row_addr;
    end else if (act) begin
      if (cnt == LAST_C) begin
        act <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy    = act;
  assign sel_win = act && (cnt != '0) && (cnt <= SEL_C);

  for (genvar i = 0; i < NPRE; i++) begin : g_pre
    assign pre_lo[i] = act && (row_r[HALF-1:0] == HALF'(i));
    assign pre_hi[i] = act && (row_r[ROW_W-1:HALF] == HALF'(i));
  end

  for (genvar r = 0; r < NROW; r++) begin : g_gwl
    assign gwl[r] = pre_lo[r % NPRE] & pre_hi[r / NPRE];
  end

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    assign bsel[b] = sel_win && (blk_r == BLK_W'(b));
    for (genvar r = 0; r < NROW; r++) begin : g_lwl
      assign lwl[b*NROW + r] = gwl[r] & bsel[b];
    end
  end

  p_one_lwl_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lwl));
  p_one_bsel_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bsel));
  p_pre_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|gwl) |-> ($countones(pre_lo) == 1 && $countones(pre_hi) == 1));
  p_cover_r7: assert property (@(posedge clk) disable iff (!rst_n) (|bsel) |-> (|gwl));
  p_lead_r7: assert property (@(posedge clk) disable iff (!rst_n) $rose(|bsel) |-> $past(|gwl));
  p_trail_r7: assert property (@(posedge clk) disable iff (!rst_n) $fell(|bsel) |-> (|gwl));
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && busy) |=> ($stable(row_r) && $stable(blk_r)));
endmodule

// File: tb/hwl_decoder_tb.sv
module hwl_decoder_tb_top;
  localparam int ROW_W = 4;
  localparam int NB    = 4;
  localparam int SEL   = 3;
  localparam int BW    = 2;
  localparam int NPRE  = 1 << (ROW_W/2);
  localparam int NROW  = 1 << ROW_W;

  logic clk = 0, rst_n = 0, strobe = 0;
  logic [BW-1:0] blk_addr = '0;
  logic [ROW_W-1:0] row_addr = '0;
  logic busy;
  logic [NPRE-1:0] pre_lo, pre_hi;
  logic [NROW-1:0] gwl;
  logic [NB-1:0] bsel;
  logic [NB*NROW-1:0] lwl;

  int errors = 0, checks = 0;
  int qb[$], qr[$];
  bit done = 0;

  always #5 clk = ~clk;

  hwl_decoder #(.ROW_W(ROW_W), .N_BLK(NB), .SEL_CYC(SEL)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .blk_addr(blk_addr), .row_addr(row_addr),
    .busy(busy), .pre_lo(pre_lo), .pre_hi(pre_hi), .gwl(gwl), .bsel(bsel), .lwl(lwl));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic access(input int b, input int r, input int hold);
    @(negedge clk);
    while (busy) @(negedge clk);
    strobe = 1; blk_addr = BW'(b); row_addr = ROW_W'(r);
    qb.push_back(b); qr.push_back(r);
    repeat (hold) @(negedge clk);
    strobe = 0;
  endtask

  // launch a pulse, then drive a stray strobe k cycles later while busy (R8)
  task automatic launch_poke(input int b, input int r, input int pb, input int pr, input int k);
    access(b, r, 1);
    repeat (k-1) @(negedge clk);
    strobe = 1; blk_addr = BW'(pb); row_addr = ROW_W'(pr);
    @(negedge clk);
    strobe = 0;
  endtask

  // scoreboard monitor
  initial begin
    bit inp = 0;
    int ph = 0, eb = 0, er = 0;
    forever begin
      @(negedge clk); #2;
      if (!rst_n) begin
        chk(gwl == 0 && bsel == 0 && lwl == 0 && pre_lo == 0 && pre_hi == 0 && !busy,
            "R1 reset clears outputs", {gwl, bsel, lwl[43:0]}, 64'h0);
        inp = 0;
      end else if (!inp) begin
        if (gwl != 0) begin
          chk(qb.size() != 0, "R8 unexpected pulse", 64'(gwl), 64'h0);
          if (qb.size() != 0) begin
            eb = qb.pop_front(); er = qr.pop_front();
          end
          inp = 1; ph = 0;
        end else begin
          chk(bsel == 0 && lwl == 0 && pre_lo == 0 && pre_hi == 0, "R2 idle outputs zero",
              64'(lwl), 64'h0);
        end
      end else ph++;
      if (rst_n && inp) begin
        logic [63:0] eg, ebs, el;
        bit on_sel;
        on_sel = (ph >= 1 && ph <= SEL);
        eg  = (ph <= SEL+1) ? (64'd1 << er) : 64'd0;
        ebs = on_sel ? (64'd1 << eb) : 64'd0;
        el  = on_sel ? (64'd1 << (eb*NROW + er)) : 64'd0;
        if (ph <= SEL+1) begin
          chk(64'(pre_lo) == (64'd1 << (er % NPRE)), "R2 pre_lo", 64'(pre_lo), 64'd1 << (er % NPRE));
          chk(64'(pre_hi) == (64'd1 << (er / NPRE)), "R2 pre_hi", 64'(pre_hi), 64'd1 << (er / NPRE));
          chk(busy, "R8 busy during pulse", 64'(busy), 64'd1);
        end
        chk(64'(gwl) == eg, "R3 R6 global wordline", 64'(gwl), eg);
        chk(64'(bsel) == ebs, "R5 R6 R7 block select", 64'(bsel), ebs);
        chk(64'(lwl) == el, "R4 R5 local wordline", 64'(lwl), el);
        if (ph == SEL+2) begin
          chk(!busy, "R8 busy falls with gwl", 64'(busy), 64'd0);
          inp = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 R4: every block and row
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NROW; r++) access(b, r, 1);
    // R8: held strobes do not widen the pulse
    access(2, 9, 2);
    access(1, 6, SEL+3);
    // R8: stray strobe in the first and in the last busy cycle
    launch_poke(3, 5, 0, 12, 1);
    launch_poke(0, 15, 3, 1, SEL+2);
    // R9: back-to-back pulses
    access(1, 3, 1);
    access(2, 10, 1);
    // R1: reset during a pulse
    access(3, 7, 1);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    access(0, 0, 1);
    repeat (SEL + 6) @(negedge clk);
    chk(qb.size() == 0, "R8 all launches produced pulses", 64'(qb.size()), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule